// File: doc/BRIEF.md
# Serial-to-Parallel Shift-and-Store Register

This block turns a serial bit stream into a parallel word. An eight-stage shift chain takes one bit on every rising edge of its clock. Behind it sits a level-sensitive holding stage. While the strobe is high the holding stage follows the chain. While the strobe is low it keeps its value, so the parallel pins stay still while the next word is shifted in. The parallel pins show the held word only while the output enable is high. At all other times they float, so several of these registers can share one bus.

Two serial taps carry the last stage of the chain out to a following instance. The early tap changes right after each rising edge and suits chains whose clock edges are sharp. The late tap repeats the same bit half a clock later, on the falling edge, for chains where edge skew is a concern. Feeding either tap into the serial input of a second instance gives one longer chain. The serial data has no valid/ready handshake. The shift clock is the only pacing, so the source must present a bit before every rising edge, and the register cannot apply back-pressure. An active-low asynchronous reset clears the chain, the holding stage and the late tap.

Top module: `sipo_store_reg`

## Requirements
- R1: On every rising clock edge the serial input enters stage 0, and each stage n (n = 1..W-1, W = 8 by default) takes the previous value of stage n-1.
- R2: While the strobe is high, holding bit i equals shift stage i, with no clock edge needed.
- R3: While the strobe is low, the holding stage keeps its value, however many shifts occur.
- R4: While the output enable is high, parallel pin i drives holding bit i. Pin 0 belongs to the stage nearest the serial input, and pin W-1 to the stage furthest from it.
- R5: While the output enable is low, all W parallel pins are high-impedance.
- R6: The early serial tap equals stage W-1 and changes only on rising clock edges.
- R7: The late serial tap takes stage W-1 on each falling clock edge and holds it across rising edges. It therefore lags the early tap by half a clock.
- R8: Neither the strobe nor the output enable affects shifting or either serial tap. The serial taps are never high-impedance.
- R9: While reset is low, the shift stages, the holding stage and the late tap are all zero.
- R10: When either serial tap of one instance drives the serial input of a second instance, the pair acts as a single 2W-stage chain. A bit shifted in reaches the second instance's early tap after 2W rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock; rising edge shifts, falling edge updates the late tap |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_in | input | 1 | Serial data bit, sampled on the rising edge |
| strobe | input | 1 | High: holding stage follows the chain; low: it holds |
| oe | input | 1 | High: parallel pins driven; low: parallel pins float |
| par_q | output | W | Parallel word, bit 0 nearest the serial input |
| ser_rise | output | 1 | Early cascade tap, last stage, rising-edge timed |
| ser_fall | output | 1 | Late cascade tap, last stage, falling-edge timed |

## Verification
On every cycle, the assertions check the one-stage shift step and the rule that the early tap carries the old next-to-last stage. They also check that the late tap matches the early tap at each rising edge, that the holding stage follows the chain under a high strobe and stays stable under a low one, that the enabled pins reflect the holding stage, and that reset clears the state. Other behaviours show only in the bench scenarios, which run two chained instances. These are the end-to-end order of sixteen bits through both instances under each cascade tap, and the measured half-clock lag between the taps. They also include the floating of the parallel pins, seen as pull-up and pull-down levels on the bench nets, and the fact that the serial stream continues unbroken while strobe and enable change.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
  // Default depth of one shift-and-store register.
  localparam int unsigned SIPO_STAGES_DEF = 8;
  // Smallest depth for which the chain and its taps make sense.
  localparam int unsigned SIPO_STAGES_MIN = 2;
endpackage

// File: rtl/sipo_shift_chain.sv
module sipo_shift_chain #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ser_in,
  output logic [W-1:0] stage_q
);
  // Stage 0 samples the serial input; every later stage samples its neighbour.
  for (genvar i = 0; i < W; i++) begin : g_stage
    logic d;
    if (i == 0) begin : g_head
      assign d = ser_in;
    end else begin : g_body
      assign d = stage_q[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[i] <= 1'b0;
      else        stage_q[i] <= d;
    end
  end
endmodule

// File: rtl/sipo_store_latch.sv
module sipo_store_latch #(
  parameter int unsigned W = 8
) (
  input  logic         rst_n,
  input  logic         strobe,
  input  logic [W-1:0] stage_d,
  output logic [W-1:0] store_q
);
  // Transparent while strobe is high, opaque while low.
  always_latch begin
    if (!rst_n)      store_q = '0;
    else if (strobe) store_q = stage_d;
  end
endmodule

// File: rtl/sipo_par_driver.sv
module sipo_par_driver #(
  parameter int unsigned W = 8
) (
  input  logic         oe,
  input  logic [W-1:0] store_q,
  output logic [W-1:0] par_q
);
  // One three-state buffer per parallel pin.
  for (genvar i = 0; i < W; i++) begin : g_pin
    assign par_q[i] = oe ? store_q[i] : 1'bz;
  end
endmodule

// File: rtl/sipo_cascade_tap.sv
module sipo_cascade_tap (
  input  logic clk,
  input  logic rst_n,
  input  logic last_stage,
  output logic ser_rise,
  output logic ser_fall
);
  // Early tap: the last stage itself, so it moves with the rising edge.
  assign ser_rise = last_stage;

  // Late tap: re-timed to the falling edge for skew-tolerant chaining.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) ser_fall <= 1'b0;
    else        ser_fall <= last_stage;
  end
endmodule

// File: rtl/sipo_store_reg.sv
module sipo_store_reg
  import sipo_pkg::*;
#(
  parameter int unsigned W = SIPO_STAGES_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ser_in,
  input  logic         strobe,
  input  logic         oe,
  output logic [W-1:0] par_q,
  output logic         ser_rise,
  output logic         ser_fall
);
  localparam int unsigned LAST = W - 1;

  logic [W-1:0] stage_q;
  logic [W-1:0] store_q;

  sipo_shift_chain #(.W(W)) u_chain (
    .clk     (clk),
    .rst_n   (rst_n),
    .ser_in  (ser_in),
    .stage_q (stage_q)
  );

  sipo_store_latch #(.W(W)) u_latch (
    .rst_n   (rst_n),
    .strobe  (strobe),
    .stage_d (stage_q),
    .store_q (store_q)
  );

  sipo_par_driver #(.W(W)) u_drv (
    .oe      (oe),
    .store_q (store_q),
    .par_q   (par_q)
  );

  sipo_cascade_tap u_tap (
    .clk        (clk),
    .rst_n      (rst_n),
    .last_stage (stage_q[LAST]),
    .ser_rise   (ser_rise),
    .ser_fall   (ser_fall)
  );
endmodule

// File: rtl/sipo_store_reg_chk.sv
module sipo_store_reg_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ser_in,
  input logic         strobe,
  input logic         oe,
  input logic [W-1:0] stage,
  input logic [W-1:0] store,
  input logic [W-1:0] par_q,
  input logic         ser_rise,
  input logic         ser_fall
);
  a_r1_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> stage == {$past(stage[W-2:0]), $past(ser_in)});

  a_r6_early_tap: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ser_rise == $past(stage[W-2]));

  a_r7_late_matches_early: assert property (@(posedge clk) disable iff (!rst_n)
    ser_fall == ser_rise);

  a_r2_follow: assert property (@(negedge clk) disable iff (!rst_n)
    strobe |-> store == stage);

  a_r3_hold: assert property (@(negedge clk) disable iff (!rst_n)
    (!strobe && $past(!strobe)) |-> $stable(store));

  a_r4_drive: assert property (@(negedge clk) disable iff (!rst_n)
    oe |-> par_q == store);

  a_r9_reset_clear: assert property (@(posedge clk)
    !rst_n |-> (stage == '0 && store == '0 && ser_fall == 1'b0));
endmodule

bind sipo_store_reg sipo_store_reg_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ser_in   (ser_in),
  .strobe   (strobe),
  .oe       (oe),
  .stage    (stage_q),
  .store    (store_q),
  .par_q    (par_q),
  .ser_rise (ser_rise),
  .ser_fall (ser_fall)
);

// File: tb/sipo_store_reg_test.sv
`timescale 1ns/1ps
module sipo_store_reg_test;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic a_in = 1'b0;
  logic strobe = 1'b1;
  logic oe = 1'b1;
  logic use_fall = 1'b0;

  tri1 [W-1:0] par_a;   // floats high when released (R5)
  tri0 [W-1:0] par_b;   // floats low when released (R5)
  logic a_rise, a_fall, b_rise, b_fall, b_in;

  int nchk = 0;
  int nfail = 0;

  logic sb[$];      // scoreboard of bits pushed into the chain
  logic hist[$];    // full history of shifted bits
  logic [2*W-1:0] held = '0;
  logic prev_stb = 1'b1;
  logic prev_out = 1'b0;
  bit   prev_valid = 1'b0;

  always #5 clk = ~clk;

  assign b_in = use_fall ? a_fall : a_rise;

  sipo_store_reg #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .ser_in(a_in), .strobe(strobe), .oe(oe),
    .par_q(par_a), .ser_rise(a_rise), .ser_fall(a_fall)
  );

  sipo_store_reg #(.W(W)) u_next (
    .clk(clk), .rst_n(rst_n), .ser_in(b_in), .strobe(strobe), .oe(oe),
    .par_q(par_b), .ser_rise(b_rise), .ser_fall(b_fall)
  );

  task automatic chk(input string req, input logic [2*W-1:0] act,
                     input logic [2*W-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  // Expected 2W-stage contents from history (R1, R10)
  function automatic logic [2*W-1:0] chain_now();
    logic [2*W-1:0] v = '0;
    for (int k = 0; k < 2*W; k++)
      if (k < hist.size()) v[k] = hist[hist.size()-1-k];
    return v;
  endfunction

  // Every rising edge out of reset is a shift: record what went in.
  always @(posedge clk) begin
    if (rst_n) begin
      sb.push_back(a_in);
      hist.push_back(a_in);
    end
  end

  // Monitor: bits leave the far end of the chain in push order.
  always @(posedge clk) begin
    #4;
    if (sb.size() >= 2*W) begin
      logic e;
      e = sb.pop_front();
      chk("R10 R6 R8 chained early tap", {15'b0, b_rise}, {15'b0, e});
      if (prev_valid)
        chk("R7 late tap lags before falling edge", {15'b0, b_fall}, {15'b0, prev_out});
      #3;
      chk("R7 R8 late tap after falling edge", {15'b0, b_fall}, {15'b0, e});
      prev_out = e;
      prev_valid = 1'b1;
    end
  end

  // One clock of stimulus, then check of the parallel pins.
  task automatic cyc(input logic b, input logic stb, input logic en);
    logic [2*W-1:0] cur;
    @(posedge clk);
    #1;
    a_in = b; strobe = stb; oe = en;
    #3;
    cur = chain_now();
    if (stb || prev_stb) held = cur;
    prev_stb = stb;
    if (en) begin
      chk(stb ? "R2 R4 first stage follows" : "R3 R4 first stage holds",
          {8'h00, par_a}, {8'h00, held[W-1:0]});
      chk(stb ? "R2 R4 second stage follows" : "R3 R4 second stage holds",
          {8'h00, par_b}, {8'h00, held[2*W-1:W]});
    end else begin
      chk("R5 first pins float (pull-up)", {8'h00, par_a}, {8'h00, 8'hFF});
      chk("R5 second pins float (pull-down)", {8'h00, par_b}, 16'h0000);
    end
  endtask

  function automatic logic pat(input int i);
    return logic'(((i * 37) >> 2) & 1) ^ logic'(i % 5 == 0);
  endfunction

  initial begin
    #2 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #4;
    // R9: reset clears everything, pins show zero while enabled
    chk("R9 reset first pins", {8'h00, par_a}, 16'h0000);
    chk("R9 reset second pins", {8'h00, par_b}, 16'h0000);
    chk("R9 reset taps", {14'b0, b_rise, b_fall}, 16'h0000);
    chk("R9 reset first late tap", {15'b0, a_fall}, 16'h0000);
    #1 a_in = 1'b1;
    @(posedge clk); #1 rst_n = 1'b1;

    // R1 R10: rising-tap cascade, transparent storage
    for (int i = 0; i < 24; i++) cyc(pat(i), 1'b1, 1'b1);
    // R10: switch the chain to the falling-edge tap mid-stream
    use_fall = 1'b1;
    for (int i = 24; i < 48; i++) cyc(pat(i), 1'b1, 1'b1);
    // R3: strobe low, storage holds while shifting continues (R8)
    for (int i = 48; i < 58; i++) cyc(~pat(i), 1'b0, 1'b1);
    // R5: enable low, pins float; serial stream unaffected (R8)
    for (int i = 58; i < 64; i++) cyc(pat(i), 1'b0, 1'b0);
    for (int i = 64; i < 68; i++) cyc(1'b1, 1'b1, 1'b0);
    // R2 R4: re-enable, storage tracks the chain again
    for (int i = 68; i < 74; i++) cyc(pat(i), 1'b1, 1'b1);
    for (int i = 74; i < 78; i++) cyc(1'b0, 1'b0, 1'b1);
    use_fall = 1'b0;
    for (int i = 78; i < 98; i++) cyc(pat(i + 3), 1'b1, 1'b1);
    repeat (2) @(posedge clk);
    #8;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #100000;
    nchk++;
    nfail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule